// File: doc/BRIEF.md
# Edge-Triggered Counter Capture with Run-Length Filter

This block takes a snapshot of a free-running 16-bit timer count whenever a chosen transition shows up on an asynchronous external capture pin. The pin first passes through a two-flop synchronizer. An optional run-length filter can follow it, so that short glitches are rejected before edge detection. A configuration input picks the active edge, either rising or falling.

When a qualifying edge is seen, the current count is latched into the capture register and a sticky capture flag is set. That flag raises an interrupt request when the interrupt enable is high. Software clears the flag with a single-cycle write-one strobe. The capture path is shut off while the capture register is being used as the timer's TOP value.

Top module: `capture_unit`

## Requirements
- R1: With the filter off, a pin transition applied just after a clock edge is captured on the third following rising clock edge. The first two edges are spent in the synchronizer.
- R2: With edge select at 1, a low-to-high pin transition triggers a capture and a high-to-low transition does not.
- R3: With edge select at 0, a high-to-low pin transition triggers a capture and a low-to-high transition does not.
- R4: On a capture, the capture register takes the counter value present at the clock edge that performs the capture.
- R5: A capture sets the capture flag. The flag then stays set until it is cleared.
- R6: The interrupt request equals the capture flag gated by the interrupt enable.
- R7: With the filter on, the filtered pin changes only after four consecutive samples all hold the new value. A pulse lasting three samples or less never causes a capture.
- R8: With the filter on, a capture happens exactly four clock cycles later than it would with the filter off.
- R9: While the capture register serves as TOP, no capture occurs and the capture register holds its value. Releasing that mode does not produce a late capture.
- R10: A one-cycle clear strobe resets the flag on the next edge. If a capture happens on that same edge, the flag ends up set.
- R11: Changing the edge select while the pin is steady produces no capture.
- R12: Reset sets the capture register, the flag, the interrupt request and all filter state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntVal | input | 16 | Current timer count |
| pinRaw | input | 1 | Asynchronous capture pin |
| filtEn | input | 1 | 1 enables the four-sample run-length filter |
| edgeRise | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| irqEn | input | 1 | Capture interrupt enable |
| topIsCapReg | input | 1 | 1 while the capture register is the timer TOP; this blocks capture |
| flagClr | input | 1 | Write-one clear strobe for the flag |
| capReg | output | 16 | Captured count |
| capFlag | output | 1 | Sticky capture flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench changes the pin just after a falling clock edge and counts rising edges from that point. On the unfiltered path the capture lands on the third edge and carries the count present at that edge. With the filter on, the same capture lands on the seventh edge. The bench samples the outputs on the falling edge one cycle before each of these captures, to confirm the flag is still low, and again on the falling edge right after, to confirm the flag and value. Flag-clear and set-wins results are read one edge after the strobe. The interrupt request is combinational, so it is read in the same cycle the enable changes.

// File: rtl/capt_pkg.sv
package capt_pkg;
  // Control-to-datapath strobes, valid for one cycle
  typedef struct packed {
    logic load;   // take the counter value and set the flag
    logic clear;  // clear the flag unless load is also high
  } captStrobes_t;
endpackage

// File: rtl/capt_sync.sv
module capt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/capt_filter.sv
module capt_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sample,
  output logic filtered
);
  localparam int HIST_W = RUN_LEN - 1;

  logic [HIST_W-1:0] hist;
  logic              filtQ;
  logic              runComplete;

  generate
    if (HIST_W == 1) begin : g_short
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else       hist <= sample;
      end
    end else begin : g_long
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else       hist <= {hist[HIST_W-2:0], sample};
      end
    end
  endgenerate

  // The current sample plus HIST_W older ones all agree and differ from the output
  assign runComplete = (hist == {HIST_W{sample}}) && (sample != filtQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            filtQ <= 1'b0;
    else if (runComplete) filtQ <= sample;
  end

  assign filtered = filtQ;
endmodule

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinRaw,
  input  logic         filtEn,
  input  logic         edgeRise,
  input  logic         topIsCapReg,
  input  logic         flagClr,
  output captStrobes_t stb
);
  logic pinSync;
  logic pinFilt;
  logic pinSel;
  logic prevQ;
  logic edgeQ;
  logic filtEnQ;
  logic sawRise;
  logic sawFall;
  logic edgeHit;
  logic cfgChange;

  capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinRaw),
    .dout (pinSync)
  );

  capt_filter #(.RUN_LEN(RUN_LEN)) u_filter (
    .clk      (clk),
    .rstN     (rstN),
    .sample   (pinSync),
    .filtered (pinFilt)
  );

  assign pinSel = filtEn ? pinFilt : pinSync;

  // The previous-sample register reloads every cycle, including the cycle a setting changes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= 1'b0;
      edgeQ   <= 1'b0;
      filtEnQ <= 1'b0;
    end else begin
      prevQ   <= pinSel;
      edgeQ   <= edgeRise;
      filtEnQ <= filtEn;
    end
  end

  assign sawRise   = pinSel & ~prevQ;
  assign sawFall   = ~pinSel & prevQ;
  assign edgeHit   = edgeRise ? sawRise : sawFall;
  assign cfgChange = (edgeRise != edgeQ) || (filtEn != filtEnQ);

  always_comb begin
    stb.load  = edgeHit & ~cfgChange & ~topIsCapReg;
    stb.clear = flagClr;
  end
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  captStrobes_t     stb,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             irqEn,
  output logic [CNT_W-1:0] capReg,
  output logic             capFlag,
  output logic             irqReq
);
  logic [CNT_W-1:0] capQ;
  logic             flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         capQ <= '0;
    else if (stb.load) capQ <= cntVal;
  end

  // A capture in the same cycle as a clear takes priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          flagQ <= 1'b0;
    else if (stb.load)  flagQ <= 1'b1;
    else if (stb.clear) flagQ <= 1'b0;
  end

  assign capReg  = capQ;
  assign capFlag = flagQ;
  assign irqReq  = flagQ & irqEn;
endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import capt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             pinRaw,
  input  logic             filtEn,
  input  logic             edgeRise,
  input  logic             irqEn,
  input  logic             topIsCapReg,
  input  logic             flagClr,
  output logic [CNT_W-1:0] capReg,
  output logic             capFlag,
  output logic             irqReq
);
  captStrobes_t stb;

  capt_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pinRaw      (pinRaw),
    .filtEn      (filtEn),
    .edgeRise    (edgeRise),
    .topIsCapReg (topIsCapReg),
    .flagClr     (flagClr),
    .stb         (stb)
  );

  capt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntVal  (cntVal),
    .irqEn   (irqEn),
    .capReg  (capReg),
    .capFlag (capFlag),
    .irqReq  (irqReq)
  );
endmodule

// File: rtl/capt_checker.sv
module capt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic             pinRaw,
  input logic             filtEn,
  input logic             edgeRise,
  input logic             irqEn,
  input logic             topIsCapReg,
  input logic             flagClr,
  input logic [CNT_W-1:0] capReg,
  input logic             capFlag,
  input logic             irqReq
);
  // R9
  top_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    topIsCapReg |=> $stable(capReg));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    capFlag && !flagClr |=> capFlag);

  // R5
  load_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capReg) |-> capFlag);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> capFlag);

  // R10
  clear_when_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && topIsCapReg |=> !capFlag);
endmodule

bind capture_unit capt_checker #(.CNT_W(CNT_W)) u_capt_checker (.*);

// File: tb/capture_unit_bench.sv
module capture_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cntVal;
  logic        pinRaw, filtEn, edgeRise, irqEn, topIsCapReg, flagClr;
  logic [15:0] capReg;
  logic        capFlag, irqReq;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_unit u_capture_unit (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .pinRaw(pinRaw), .filtEn(filtEn),
    .edgeRise(edgeRise), .irqEn(irqEn), .topIsCapReg(topIsCapReg),
    .flagClr(flagClr), .capReg(capReg), .capFlag(capFlag), .irqReq(irqReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance n cycles; inputs change only on falling edges
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cntVal = cntVal + 16'd1;
    end
  endtask

  task automatic settle(input logic lvl);
    pinRaw = lvl;
    tick(12);
    flagClr = 1'b1;
    tick(1);
    flagClr = 1'b0;
  endtask

  task automatic test_reset();
    check(capReg == 16'd0, "R12 capReg", capReg, 0);
    check(capFlag == 1'b0, "R12 capFlag", capFlag, 0);
    check(irqReq == 1'b0, "R12 irqReq", irqReq, 0);
  endtask

  task automatic test_rise_unfiltered();
    logic [15:0] c;
    filtEn = 0; edgeRise = 1; settle(0);
    pinRaw = 1; c = cntVal;
    tick(2);
    check(capFlag == 0, "R1 no capture before third edge", capFlag, 0);
    tick(1);
    check(capFlag == 1, "R5 flag set on rising (R2)", capFlag, 1);
    check(capReg == c + 16'd2, "R4 captured count (R1)", capReg, c + 16'd2);
    irqEn = 0; #1;
    check(irqReq == 0, "R6 irq masked", irqReq, 0);
    irqEn = 1; #1;
    check(irqReq == 1, "R6 irq raised", irqReq, 1);
    tick(5);
    check(capFlag == 1, "R5 flag sticky", capFlag, 1);
    flagClr = 1; tick(1); flagClr = 0;
    check(capFlag == 0, "R10 clear strobe", capFlag, 0);
    check(irqReq == 0, "R6 irq drops with flag", irqReq, 0);
    pinRaw = 0; tick(8);
    check(capFlag == 0, "R2 falling ignored when rising selected", capFlag, 0);
  endtask

  task automatic test_fall_unfiltered();
    logic [15:0] c;
    filtEn = 0; edgeRise = 0; settle(1);
    pinRaw = 0; c = cntVal;
    tick(3);
    check(capFlag == 1, "R3 falling captured", capFlag, 1);
    check(capReg == c + 16'd2, "R3 falling count", capReg, c + 16'd2);
    flagClr = 1; tick(1); flagClr = 0;
    pinRaw = 1; tick(8);
    check(capFlag == 0, "R3 rising ignored when falling selected", capFlag, 0);
  endtask

  task automatic test_filtered_delay();
    logic [15:0] c;
    filtEn = 1; edgeRise = 1; settle(0);
    pinRaw = 1; c = cntVal;
    tick(6);
    check(capFlag == 0, "R8 filtered not early", capFlag, 0);
    tick(1);
    check(capFlag == 1, "R8 filtered capture", capFlag, 1);
    check(capReg == c + 16'd6, "R8 filtered count", capReg, c + 16'd6);
  endtask

  task automatic test_glitch();
    logic [15:0] held;
    filtEn = 1; edgeRise = 1; settle(0);
    held = capReg;
    pinRaw = 1; tick(3); pinRaw = 0; tick(10);
    check(capFlag == 0, "R7 short pulse rejected", capFlag, 0);
    check(capReg == held, "R7 register untouched", capReg, held);
  endtask

  task automatic test_top_block();
    logic [15:0] held;
    filtEn = 0; edgeRise = 1; settle(0);
    topIsCapReg = 1; held = capReg;
    pinRaw = 1; tick(6);
    check(capFlag == 0, "R9 no flag under TOP", capFlag, 0);
    check(capReg == held, "R9 register held", capReg, held);
    topIsCapReg = 0; tick(5);
    check(capFlag == 0, "R9 no late capture", capFlag, 0);
  endtask

  task automatic test_set_wins();
    logic [15:0] c;
    filtEn = 0; edgeRise = 1; settle(0);
    pinRaw = 1; c = cntVal;
    tick(2);
    flagClr = 1; tick(1); flagClr = 0;
    check(capFlag == 1, "R10 set wins over clear", capFlag, 1);
    check(capReg == c + 16'd2, "R10 count on collision", capReg, c + 16'd2);
  endtask

  task automatic test_edge_change();
    filtEn = 0; edgeRise = 1; settle(1);
    edgeRise = 0; tick(3);
    edgeRise = 1; tick(3);
    check(capFlag == 0, "R11 select change no capture", capFlag, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; cntVal = 16'h1234; pinRaw = 0; filtEn = 0; edgeRise = 0;
    irqEn = 0; topIsCapReg = 0; flagClr = 0;
    tick(3);
    rstN = 1;
    tick(1);
    test_reset();
    test_rise_unfiltered();
    test_fall_unfiltered();
    test_filtered_delay();
    test_glitch();
    test_top_block();
    test_set_wins();
    test_edge_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule